// File: doc/BRIEF.md
# Inverting Read/Write Word Store (16 x 4)

This block is a small synchronous read/write memory of sixteen 4-bit words. Three things are sampled on the system clock: an active-low select, an active-low write strobe and a 4-bit address with 4-bit write data. A sampled clock cycle is in one of three modes. With select high the block is inhibited. With select low and strobe high it reads. With select low and strobe low it writes.

Read data leaves the block inverted. The output is a 4-bit word plus an enable, and a tri-state copy of the word floats whenever the enable is low. The enable is low during writes as well as during deselection.

A write does not land while the strobe is low. It lands when the strobe is released. The address is taken from the first low sample and the data from the last low sample. The block refuses the write and raises a one-cycle flag in three cases: the strobe was too short, the address moved during the strobe, or select rose before the release had been seen. Storage has no reset, so contents are undefined until each word is written.

Top module: `inv_sram`

## Requirements
- R1: Each of the 16 words is selected by exactly one 4-bit address value, and a word written at one address reads back from that address only.
- R2: One cycle after select=0 and strobe=1 are sampled, `rd_oe` is 1 and `rd_data` is the bitwise complement of the word at the sampled address.
- R3: One cycle after select=0 and strobe=0 are sampled, `rd_oe` is 0, `rd_data` is 0 and `bus_out` is high impedance.
- R4: One cycle after select=1 is sampled, `rd_oe` is 0, `rd_data` is 0 and `bus_out` is high impedance, and no word changes whatever the strobe does.
- R5: A strobe begins on a sample with select=0 and strobe=0. It commits on the first later sample with strobe=1 and select=0, provided it had at least MIN_LOW (default 2) consecutive low samples. The committed address comes from the first low sample and the data from the last low sample.
- R6: In the release cycle of a committing strobe, a read of the same address already shows the complement of the newly written data.
- R7: A strobe with fewer than MIN_LOW low samples writes nothing, and `width_viol` is 1 for exactly the release cycle.
- R8: If the sampled address differs from the first-low-sample address in any later low sample or in the release sample, nothing is written and `addr_viol` is 1 for exactly the release cycle.
- R9: If select is sampled high while a strobe is in progress (strobe still low or just released), the strobe is dropped without a write and `cs_viol` is 1 for that cycle.
- R10: After a synchronous active-low reset, `rd_oe`, `rd_data` and all three violation flags are 0, `bus_out` floats, and no strobe is in progress.
- R11: `bus_out` equals `rd_data` while `rd_oe` is 1 and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 4 | Word address |
| din | input | 4 | Write data |
| rd_data | output | 4 | Inverted read word, 0 when not driving |
| rd_oe | output | 1 | Output enable, 1 only in read mode |
| bus_out | output | 4 | Tri-state copy of `rd_data` |
| addr_viol | output | 1 | One-cycle pulse: address moved during a strobe |
| width_viol | output | 1 | One-cycle pulse: strobe shorter than MIN_LOW samples |
| cs_viol | output | 1 | One-cycle pulse: select rose during a strobe |

## Verification
Every address is first written with a pattern derived from the address, with the data changed between the two low samples, and is then read back. This separates a correct decode and inversion from aliasing, from a missing complement and from a write that uses the first data sample instead of the last. Directed strobes then hit each rule in turn: one that is too short, one whose address moves, one dropped by select, and a strobe held low while deselected. After each, reads of the affected words show that the word was untouched and that only the matching flag pulsed. A seeded random mix of all these operations over random addresses and data then runs against a word-by-word model, with the release-cycle forward read checked on every good write.

// File: rtl/inv_ram_pkg.sv
`timescale 1ns/1ps
// Package: shared mode type for the inverting word store.
// Assumes: nothing beyond the sampled select/strobe pair.
package inv_ram_pkg;
    typedef enum logic [1:0] {
        OP_INHIBIT = 2'd0,
        OP_READ    = 2'd1,
        OP_WRITE   = 2'd2
    } ram_op_e;

    // Decode a sampled select/strobe pair into the cycle's mode.
    function automatic ram_op_e decode_op(input logic sel_n, input logic stb_n);
        if (sel_n)      return OP_INHIBIT;
        else if (stb_n) return OP_READ;
        else            return OP_WRITE;
    endfunction
endpackage

// File: rtl/inv_ram_strobe.sv
`timescale 1ns/1ps
// Module: inv_ram_strobe
// Tracks one write strobe from its first low sample to its release and
// decides whether it commits. Address is held from the first low sample,
// data from the last. Width, address and select rules raise one-cycle flags.
// Assumes: inputs are already registered by the top.
module inv_ram_strobe #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 4,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_cs_n,
    input  logic              s_we_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_din,
    output logic              commit,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data,
    output logic              addr_viol,
    output logic              width_viol,
    output logic              cs_viol
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic              active_q;
    logic [CW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              moved_q;

    logic start, keep_low, abort, release_s, addr_bad, too_short;

    // Classify the current sample relative to the strobe state.
    always_comb begin
        start     = !active_q && !s_cs_n && !s_we_n;
        keep_low  = active_q && !s_cs_n && !s_we_n;
        abort     = active_q && s_cs_n;
        release_s = active_q && !s_cs_n && s_we_n;
        addr_bad  = moved_q || (s_addr != addr_q);
        too_short = int'(cnt_q) < MIN_LOW;
    end

    // Drive the commit decision and the violation pulses.
    always_comb begin
        cs_viol    = abort;
        width_viol = release_s && too_short;
        addr_viol  = release_s && addr_bad;
        commit     = release_s && !too_short && !addr_bad;
        c_addr     = addr_q;
        c_data     = data_q;
    end

    // Advance the strobe tracker on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            moved_q  <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= CW'(1);
            addr_q   <= s_addr;
            data_q   <= s_din;
            moved_q  <= 1'b0;
        end else if (keep_low) begin
            if (too_short) cnt_q <= cnt_q + 1'b1;
            data_q  <= s_din;
            moved_q <= moved_q || (s_addr != addr_q);
        end else if (abort || release_s) begin
            active_q <= 1'b0;
        end
    end

    // R5
    commit_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!s_we_n && !s_cs_n));

    // R9
    abort_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_viol |=> !commit);
endmodule

// File: rtl/inv_ram_array.sv
`timescale 1ns/1ps
// Module: inv_ram_array
// Word storage with a fully decoded per-word write enable and a
// combinational read port.
// Assumes: contents are undefined until written; there is no reset of storage.
module inv_ram_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  word_we;

    // One decoded write enable per word.
    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign word_we[i] = we && (waddr == ADDR_W'(i));
    end

    // Store the write word into the selected location.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (word_we[i]) mem_q[i] <= wdata;
        end
    end

    // Read the addressed word.
    always_comb rword = mem_q[raddr];

    // R1
    decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_we));

    // R1
    decode_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $countones(word_we) == 1);
endmodule

// File: rtl/inv_ram_out.sv
`timescale 1ns/1ps
// Module: inv_ram_out
// Output stage: forwards a word committing this cycle, inverts the read
// word, generates the enable and the tri-state copy.
// Assumes: commit only occurs in a read-mode sample.
module inv_ram_out
    import inv_ram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  ram_op_e           op,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] rword,
    input  logic              commit,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output wire  [DATA_W-1:0] bus_out
);
    logic [DATA_W-1:0] word;

    // Choose between the stored word and a same-cycle commit, then invert.
    always_comb begin
        rd_oe   = (op == OP_READ);
        word    = (commit && (c_addr == s_addr)) ? c_data : rword;
        rd_data = rd_oe ? ~word : '0;
    end

    assign bus_out = rd_oe ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/inv_sram.sv
`timescale 1ns/1ps
// Module: inv_sram (top)
// Sixteen-word inverting store with a released-strobe write and a
// tri-state read port. Registers the inputs once, then tracks the strobe,
// stores words and drives the output.
// Assumes: synchronous active-low reset; storage contents undefined after it.
module inv_sram
    import inv_ram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 4,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output wire  [DATA_W-1:0] bus_out,
    output logic              addr_viol,
    output logic              width_viol,
    output logic              cs_viol
);
    logic              s_cs_n, s_we_n;
    logic [ADDR_W-1:0] s_addr, c_addr;
    logic [DATA_W-1:0] s_din, c_data, rword;
    logic              commit;
    ram_op_e           op;

    // Sample all inputs on the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cs_n <= 1'b1;
            s_we_n <= 1'b1;
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            s_cs_n <= cs_n;
            s_we_n <= we_n;
            s_addr <= addr;
            s_din  <= din;
        end
    end

    // Decode the sampled mode.
    always_comb op = decode_op(s_cs_n, s_we_n);

    inv_ram_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .s_cs_n(s_cs_n), .s_we_n(s_we_n),
        .s_addr(s_addr), .s_din(s_din), .commit(commit), .c_addr(c_addr),
        .c_data(c_data), .addr_viol(addr_viol), .width_viol(width_viol),
        .cs_viol(cs_viol)
    );

    inv_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(c_addr), .wdata(c_data),
        .raddr(s_addr), .rword(rword)
    );

    inv_ram_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .op(op), .s_addr(s_addr), .rword(rword), .commit(commit),
        .c_addr(c_addr), .c_data(c_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .bus_out(bus_out)
    );

    // R4
    inhibit_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!rd_oe && rd_data == '0));

    // R3
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> !rd_oe);

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n) |=> rd_oe);
endmodule

// File: tb/inv_sram_bench.sv
`timescale 1ns/1ps
module inv_sram_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       we_n = 1'b1;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] rd_data;
    logic       rd_oe;
    wire  [3:0] bus_out;
    logic       addr_viol, width_viol, cs_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] model [16];

    always #2.5 clk = ~clk;

    inv_sram u_inv_sram (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
        .din(din), .rd_data(rd_data), .rd_oe(rd_oe), .bus_out(bus_out),
        .addr_viol(addr_viol), .width_viol(width_viol), .cs_viol(cs_viol)
    );

    function automatic logic [3:0] inv4(input logic [3:0] v);
        return ~v;
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic see_flags(input string req, input logic a, input logic w, input logic c);
        chk({req, " flags"}, {29'd0, addr_viol, width_viol, cs_viol}, {29'd0, a, w, c});
    endtask

    task automatic see_idle(input string req);
        chk({req, " oe"}, 32'(rd_oe), 32'd0);
        chk({req, " data"}, 32'(rd_data), 32'd0);
        chk({req, " bus"}, 32'(bus_out), {28'd0, 4'bzzzz});
    endtask

    task automatic see_word(input string req, input logic [3:0] w);
        chk({req, " oe"}, 32'(rd_oe), 32'd1);
        chk({req, " data"}, 32'(rd_data), 32'(inv4(w)));
        chk({req, " bus"}, 32'(bus_out), 32'(inv4(w)));  // R11
    endtask

    task automatic do_read(input string req, input logic [3:0] a);
        cs_n = 1'b0; we_n = 1'b1; addr = a;
        tick;
        see_word(req, model[a]);
        see_flags(req, 1'b0, 1'b0, 1'b0);
        cs_n = 1'b1;
    endtask

    // Good write; data changes between the two low samples, last one counts.
    task automatic do_write(input logic [3:0] a, input logic [3:0] d1, input logic [3:0] d2);
        cs_n = 1'b0; we_n = 1'b0; addr = a; din = d1;
        tick;
        see_idle("R3 strobe low");
        din = d2;
        tick;
        we_n = 1'b1; din = ~d2;
        tick;
        see_word("R6 release forward", d2);
        see_flags("R5 clean release", 1'b0, 1'b0, 1'b0);
        model[a] = d2;
        cs_n = 1'b1;
        tick;
    endtask

    task automatic do_short(input logic [3:0] a, input logic [3:0] d);
        cs_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        tick;
        we_n = 1'b1;
        tick;
        see_flags("R7 short strobe", 1'b0, 1'b1, 1'b0);
        see_word("R7 no write", model[a]);
        cs_n = 1'b1;
        tick;
    endtask

    task automatic do_move(input logic [3:0] a, input logic [3:0] b, input logic [3:0] d);
        cs_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        tick;
        addr = b;
        tick;
        we_n = 1'b1;
        tick;
        see_flags("R8 address moved", 1'b1, 1'b0, 1'b0);
        see_word("R8 no write", model[b]);
        cs_n = 1'b1;
        tick;
    endtask

    task automatic do_abort(input logic [3:0] a, input logic [3:0] d);
        cs_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        tick;
        cs_n = 1'b1;
        tick;
        see_flags("R9 select dropped", 1'b0, 1'b0, 1'b1);
        see_idle("R9 idle");
        we_n = 1'b1;
        tick;
    endtask

    task automatic do_inhibit(input logic [3:0] a, input logic [3:0] d);
        cs_n = 1'b1; we_n = 1'b0; addr = a; din = d;
        tick;
        see_idle("R4 inhibit");
        tick;
        see_flags("R4 inhibit flags", 1'b0, 1'b0, 1'b0);
        we_n = 1'b1;
        tick;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (3) tick;
        see_idle("R10 reset");
        see_flags("R10 reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick;
        see_idle("R10 after reset");

        // R1: fill every word, then read each back.
        for (int i = 0; i < 16; i++) begin
            do_write(4'(i), 4'(~i), 4'(i) ^ 4'h5);
        end
        for (int i = 0; i < 16; i++) begin
            do_read("R1 R2 fill readback", 4'(i));
        end

        // Directed corners.
        do_short(4'd3, 4'hF);
        do_read("R7 readback", 4'd3);
        do_move(4'd4, 4'd9, 4'h0);
        do_read("R8 readback a", 4'd4);
        do_read("R8 readback b", 4'd9);
        do_abort(4'd7, ~model[7]);
        do_read("R9 readback", 4'd7);
        do_inhibit(4'd12, ~model[12]);
        do_read("R4 readback", 4'd12);
        do_write(4'd0, 4'h0, 4'hF);
        do_write(4'd15, 4'hF, 4'h0);
        do_read("R2 all ones", 4'd0);
        do_read("R2 all zeros", 4'd15);

        // Random mix against the model.
        for (int n = 0; n < 400; n++) begin
            logic [3:0] a, d;
            int op;
            a  = 4'($urandom_range(15, 0));
            d  = 4'($urandom_range(15, 0));
            op = int'($urandom_range(5, 0));
            case (op)
                0, 1: do_write(a, 4'($urandom_range(15, 0)), d);
                2:    do_read("R2 random read", a);
                3:    do_short(a, d);
                4:    do_move(a, a ^ 4'($urandom_range(15, 1)), d);
                default: begin
                    if (d[0]) do_abort(a, d);
                    else      do_inhibit(a, d);
                end
            endcase
        end
        for (int i = 0; i < 16; i++) begin
            do_read("R1 final sweep", 4'(i));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule